// File: doc/BRIEF.md
# Write Status Polling Generator

This block stands in for the busy period of an embedded program or erase operation inside a flash-style memory. The command decoder pulses `start` with an operation kind and the byte being written. The block then runs a busy timer whose length depends on that kind. While the timer runs, every read gets a status byte in place of the array data. The top bit of the status byte is a completion flag. For a byte program it is the inverse of the top bit being written; for any erase it is 0. The next bit flips on each completed read strobe. All lower bits read 0.

When the timer expires, reads go back to returning the array data unchanged. The toggle bit then holds its last value. Host software can therefore spot completion in either of two ways: the top bit matches the expected data, or two reads in a row return the same bit 6. A synchronous reset stops a running operation at once.

All durations are parameters counted in clock cycles. The defaults match real program and erase times at a 33 MHz clock, and a bench can shrink them. The `busy` output goes back to the command decoder, which uses it to ignore new commands.

Top module: `wr_status_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `busy` is 0 after that edge, and `rd_data` equals `array_data`. The toggle bit (bit 6 of the status byte) is cleared to 0.
- R2: `start` while idle raises `busy` after that edge. For a program operation (`start_op` = 2'b00), `busy` then stays high for exactly `PROG_CYCLES` cycles.
- R3: Erase lengths follow `start_op`: 2'b01 sector lasts `SECT_CYCLES`, 2'b10 block lasts `BLK_CYCLES`, and 2'b11 whole-array lasts `CHIP_CYCLES` cycles of `busy`.
- R4: While a program is busy, `rd_data[7]` is the inverse of bit 7 of `start_data` as captured at the accepted start.
- R5: While an erase is busy, `rd_data[7]` is 0.
- R6: While busy, `rd_data[5:0]` is 0.
- R7: While busy, `rd_data[6]` inverts after each cycle in which `rd_strobe` is high, and holds in cycles without a strobe.
- R8: While idle, `rd_strobe` leaves the toggle bit unchanged. The next operation's first status read shows the value the toggle bit had at the end of the previous operation.
- R9: While not busy, `rd_data` equals `array_data`, whatever `rd_strobe` does.
- R10: A `start` that arrives while busy is ignored: the running duration is not extended or changed, and `rd_data[7]` keeps the value of the running operation.
- R11: A reset asserted during a running operation clears `busy` at the next edge, and `rd_data` returns to `array_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; aborts a running operation |
| start | input | 1 | One-cycle request to begin an operation |
| start_op | input | 2 | Operation kind: 00 program, 01 sector erase, 10 block erase, 11 whole-array erase |
| start_data | input | DATA_W | Byte being programmed; only the top bit is used |
| rd_strobe | input | 1 | High for one cycle per completed host read |
| array_data | input | DATA_W | Array read data for the current read address |
| rd_data | output | DATA_W | Status byte while busy, array data otherwise |
| busy | output | 1 | High while the operation's timer runs |

## Verification
The bench builds the block with `PROG_CYCLES`=5, `SECT_CYCLES`=9, `BLK_CYCLES`=13 and `CHIP_CYCLES`=20. With these values, every operation kind runs to completion in a few dozen cycles. Each busy window can then be counted exactly, and bit 6 can be followed read by read through a whole operation. The distinct lengths make a wrong decode of `start_op` or a start that re-arms while busy visible as a wrong cycle count. The short whole-array erase leaves room for a reset part-way through and for checking the frozen toggle bit across back-to-back operations.

// File: rtl/wsg_pkg.sv
// Package: shared types and bit positions for the write status generator.
// Assumes an 8-bit or wider status byte with the flags in the top two bits.
package wsg_pkg;

    // Operation kind presented with a start request
    typedef enum logic [1:0] {
        OP_PROG = 2'b00,
        OP_SECT = 2'b01,
        OP_BLK  = 2'b10,
        OP_CHIP = 2'b11
    } wsg_op_e;

    // True for any erase kind
    function automatic logic op_is_erase(input wsg_op_e op);
        return (op != OP_PROG);
    endfunction

endpackage

// File: rtl/wsg_op_latch.sv
// Module: captures the operation context when a start is accepted.
// Holds whether the running operation is an erase and the top bit of the
// programmed byte. Assumes 'load' is only high for an accepted start.
module wsg_op_latch
    import wsg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  wsg_op_e op_in,
    input  logic    data_msb_in,
    output logic    is_erase,
    output logic    prog_msb
);

    // Register the context of the accepted operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_erase <= 1'b0;
            prog_msb <= 1'b0;
        end else if (load) begin
            is_erase <= op_is_erase(op_in);
            prog_msb <= data_msb_in;
        end
    end

endmodule

// File: rtl/wsg_busy_timer.sv
// Module: busy timer. On load it arms a down-counter with the duration of
// the requested kind and holds 'busy' high for exactly that many cycles.
// Assumes every duration parameter is at least 1.
module wsg_busy_timer
    import wsg_pkg::*;
#(
    parameter int unsigned PROG_CYCLES = 660,
    parameter int unsigned SECT_CYCLES = 594000,
    parameter int unsigned BLK_CYCLES  = 594000,
    parameter int unsigned CHIP_CYCLES = 2310000
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  wsg_op_e op_in,
    output logic    busy
);

    localparam int unsigned MAX_A  = (PROG_CYCLES > SECT_CYCLES) ? PROG_CYCLES : SECT_CYCLES;
    localparam int unsigned MAX_B  = (BLK_CYCLES > CHIP_CYCLES) ? BLK_CYCLES : CHIP_CYCLES;
    localparam int unsigned MAX_D  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CNT_W  = (MAX_D > 1) ? $clog2(MAX_D) : 1;

    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] reload;

    // Select the terminal count for the requested kind
    always_comb begin
        unique case (op_in)
            OP_PROG: reload = CNT_W'(PROG_CYCLES - 1);
            OP_SECT: reload = CNT_W'(SECT_CYCLES - 1);
            OP_BLK:  reload = CNT_W'(BLK_CYCLES - 1);
            default: reload = CNT_W'(CHIP_CYCLES - 1);
        endcase
    end

    // Arm, count down and release the busy flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            remain_q <= '0;
        end else if (load) begin
            busy     <= 1'b1;
            remain_q <= reload;
        end else if (busy) begin
            if (remain_q == '0) begin
                busy <= 1'b0;
            end else begin
                remain_q <= remain_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/wsg_toggle.sv
// Module: toggle status bit. Inverts once per completed read strobe while
// busy and holds otherwise, so it stays frozen between operations.
// Cleared only by reset.
module wsg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic rd_strobe,
    output logic tgl
);

    // Advance the toggle on a read made during an operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgl <= 1'b0;
        end else if (busy && rd_strobe) begin
            tgl <= ~tgl;
        end
    end

endmodule

// File: rtl/wsg_read_mux.sv
// Module: read data selector. While busy it assembles the status byte
// (completion flag on top, toggle bit next, zeros below); otherwise it
// passes array data through. Purely combinational.
module wsg_read_mux #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              busy,
    input  logic              flag_bit,
    input  logic              tgl,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);

    localparam int unsigned FLAG_POS = DATA_W - 1;
    localparam int unsigned TGL_POS  = DATA_W - 2;

    logic [DATA_W-1:0] status;

    // Build each status bit position
    for (genvar b = 0; b < DATA_W; b++) begin : g_status
        if (b == FLAG_POS) begin : g_flag
            assign status[b] = flag_bit;
        end else if (b == TGL_POS) begin : g_tgl
            assign status[b] = tgl;
        end else begin : g_zero
            assign status[b] = 1'b0;
        end
    end

    // Choose status or array data for the host
    always_comb begin
        rd_data = busy ? status : array_data;
    end

endmodule

// File: rtl/wr_status_gen.sv
// Module: top of the write status polling generator. Accepts a start only
// while idle, times the operation, and replaces read data by the status
// byte while busy. Assumes rst_n is synchronous and active low.
module wr_status_gen
    import wsg_pkg::*;
#(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned PROG_CYCLES = 660,
    parameter int unsigned SECT_CYCLES = 594000,
    parameter int unsigned BLK_CYCLES  = 594000,
    parameter int unsigned CHIP_CYCLES = 2310000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        start_op,
    input  logic [DATA_W-1:0] start_data,
    input  logic              rd_strobe,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy
);

    wsg_op_e op_in;
    logic    accept;
    logic    is_erase;
    logic    prog_msb;
    logic    tgl;
    logic    flag_bit;

    // Decode the request and gate it with the idle state
    always_comb begin
        op_in    = wsg_op_e'(start_op);
        accept   = start && !busy;
        flag_bit = is_erase ? 1'b0 : ~prog_msb;
    end

    wsg_op_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept),
        .op_in       (op_in),
        .data_msb_in (start_data[DATA_W-1]),
        .is_erase    (is_erase),
        .prog_msb    (prog_msb)
    );

    wsg_busy_timer #(
        .PROG_CYCLES (PROG_CYCLES),
        .SECT_CYCLES (SECT_CYCLES),
        .BLK_CYCLES  (BLK_CYCLES),
        .CHIP_CYCLES (CHIP_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .op_in (op_in),
        .busy  (busy)
    );

    wsg_toggle u_toggle (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .rd_strobe (rd_strobe),
        .tgl       (tgl)
    );

    wsg_read_mux #(
        .DATA_W (DATA_W)
    ) u_mux (
        .busy       (busy),
        .flag_bit   (flag_bit),
        .tgl        (tgl),
        .array_data (array_data),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/wr_status_gen_checker.sv
// Module: property checker for wr_status_gen, attached through bind.
// Watches only the top-level ports; a run-length counter bounds busy.
module wr_status_gen_checker #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned PROG_CYCLES = 660,
    parameter int unsigned SECT_CYCLES = 594000,
    parameter int unsigned BLK_CYCLES  = 594000,
    parameter int unsigned CHIP_CYCLES = 2310000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              rd_strobe,
    input logic [DATA_W-1:0] array_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              busy
);

    localparam int unsigned MAX_A = (PROG_CYCLES > SECT_CYCLES) ? PROG_CYCLES : SECT_CYCLES;
    localparam int unsigned MAX_B = (BLK_CYCLES > CHIP_CYCLES) ? BLK_CYCLES : CHIP_CYCLES;
    localparam int unsigned MAX_D = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned RUN_W = $clog2(MAX_D + 2);

    logic [RUN_W-1:0] run_len;

    // Count consecutive busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            run_len <= '0;
        end else begin
            run_len <= run_len + 1'b1;
        end
    end

    assert_reset_idle_R11: assert property (@(posedge clk) !rst_n |=> !busy);

    assert_start_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);

    assert_busy_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_len < RUN_W'(MAX_D));

    assert_low_bits_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> rd_data[DATA_W-3:0] == '0);

    assert_toggle_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && rd_strobe |=> (!busy || rd_data[DATA_W-2] != $past(rd_data[DATA_W-2])));

    assert_toggle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !rd_strobe |=> (!busy || $stable(rd_data[DATA_W-2])));

    assert_flag_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(rd_data[DATA_W-1])));

    assert_passthrough_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> rd_data == array_data);

endmodule

bind wr_status_gen wr_status_gen_checker #(
    .DATA_W      (DATA_W),
    .PROG_CYCLES (PROG_CYCLES),
    .SECT_CYCLES (SECT_CYCLES),
    .BLK_CYCLES  (BLK_CYCLES),
    .CHIP_CYCLES (CHIP_CYCLES)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .rd_strobe  (rd_strobe),
    .array_data (array_data),
    .rd_data    (rd_data),
    .busy       (busy)
);

// File: tb/wr_status_gen_bench.sv
// Directed bench for wr_status_gen: one task per scenario, each self-checking.
module wr_status_gen_bench;

    localparam int unsigned DW   = 8;
    localparam int unsigned P_C  = 5;
    localparam int unsigned S_C  = 9;
    localparam int unsigned B_C  = 13;
    localparam int unsigned C_C  = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    start_op = 2'b00;
    logic [DW-1:0] start_data = '0;
    logic          rd_strobe = 1'b0;
    logic [DW-1:0] array_data = 8'h3C;
    logic [DW-1:0] rd_data;
    logic          busy;

    int checks = 0;
    int failures = 0;
    logic exp_tgl = 1'b0;

    always #4 clk = ~clk;

    wr_status_gen #(
        .DATA_W (DW), .PROG_CYCLES (P_C), .SECT_CYCLES (S_C),
        .BLK_CYCLES (B_C), .CHIP_CYCLES (C_C)
    ) u_wr_status_gen (
        .clk (clk), .rst_n (rst_n), .start (start), .start_op (start_op),
        .start_data (start_data), .rd_strobe (rd_strobe),
        .array_data (array_data), .rd_data (rd_data), .busy (busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int unsigned dur(input logic [1:0] op);
        case (op)
            2'b00: return P_C;
            2'b01: return S_C;
            2'b10: return B_C;
            default: return C_C;
        endcase
    endfunction

    // Start an operation, read every read_every cycles, optionally inject a start while busy
    task automatic run_op(input string req, input logic [1:0] op, input logic [7:0] data,
                          input int read_every, input int inject_at);
        int cnt = 0;
        int cyc = 0;
        logic exp7;
        exp7 = (op == 2'b00) ? ~data[7] : 1'b0;
        @(negedge clk);
        start = 1'b1; start_op = op; start_data = data;
        @(negedge clk);
        start = 1'b0;
        forever begin
            if (!busy || cyc > 200) break;
            cnt++;
            start = (inject_at != 0 && cyc == inject_at);
            start_op = 2'b11; start_data = ~data;
            if (read_every != 0 && (cyc % read_every) == 0) begin
                rd_strobe = 1'b1;
                chk({req, " R4/R5 flag"}, 32'(rd_data[7]), 32'(exp7));
                chk("R7 toggle", 32'(rd_data[6]), 32'(exp_tgl));
                chk("R6 low bits", 32'(rd_data[5:0]), 32'h0);
                exp_tgl = ~exp_tgl;
            end else begin
                rd_strobe = 1'b0;
            end
            cyc++;
            @(negedge clk);
        end
        start = 1'b0; rd_strobe = 1'b0;
        chk({req, " duration"}, 32'(cnt), 32'(dur(op)));
        chk("R9 passthrough after end", 32'(rd_data), 32'(array_data));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 busy", 32'(busy), 32'h0);
        chk("R1 rd_data", 32'(rd_data), 32'(array_data));
        rst_n = 1'b1;
        exp_tgl = 1'b0;
    endtask

    task automatic t_program;
        array_data = 8'hA5;
        run_op("R2 program", 2'b00, 8'h80, 1, 0);
        array_data = 8'h5A;
        run_op("R2 program", 2'b00, 8'h17, 2, 0);
    endtask

    task automatic t_erases;
        array_data = 8'hFF;
        run_op("R3 sector", 2'b01, 8'hFF, 3, 0);
        run_op("R3 block", 2'b10, 8'h00, 1, 0);
        run_op("R3 chip", 2'b11, 8'h80, 4, 0);
    endtask

    task automatic t_idle_reads;
        logic [DW-1:0] v;
        array_data = 8'h66;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            rd_strobe = 1'b1;
            v = rd_data;
            chk("R9 idle read", 32'(v), 32'h66);
        end
        @(negedge clk);
        rd_strobe = 1'b0;
        // first status read of next op must show frozen toggle (R8)
        @(negedge clk);
        start = 1'b1; start_op = 2'b00; start_data = 8'h00;
        @(negedge clk);
        start = 1'b0;
        chk("R8 frozen toggle", 32'(rd_data[6]), 32'(exp_tgl));
        chk("R4 program flag", 32'(rd_data[7]), 32'h1);
        while (busy) @(negedge clk);
    endtask

    task automatic t_start_while_busy;
        array_data = 8'h11;
        run_op("R10 start ignored", 2'b00, 8'h80, 1, 2);
    endtask

    task automatic t_abort;
        array_data = 8'h42;
        @(negedge clk);
        start = 1'b1; start_op = 2'b11; start_data = 8'h00;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 busy mid-op", 32'(busy), 32'h1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 busy after reset", 32'(busy), 32'h0);
        chk("R11 rd_data after reset", 32'(rd_data), 32'h42);
        rst_n = 1'b1;
        exp_tgl = 1'b0;
        run_op("R2 after abort", 2'b00, 8'h00, 1, 0);
    endtask

    initial begin
        #(200000 * 8);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_program();
        t_erases();
        t_idle_reads();
        t_start_while_busy();
        t_abort();
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule